// File: doc/BRIEF.md
# Multibeam Beam-State Sequencer

This block is the digital control core of a four-beam, four-element beamforming device. Every beam owns its storage for beam states: a random-access store of 64 states, a sequence table that lists the order in which those states are played, and a 16-entry first-in, first-out queue. A beam state holds one attenuation code and one delay code for each of the beam's four element channels. Across the four beams this gives sixteen channel control words.

The host reaches the block through a simple parallel write port, which stands in for a serial control bus. Several devices share that bus. A write is accepted only when its 4-bit device address equals the value strapped on the `dev_addr` pins. A per-beam source select chooses among three sources: the stored states in table order, the queued states in load order, or a directly written state. New values reach the output registers only when the hardware strobe `upd` is pulsed. All sixteen channels therefore switch on the same clock edge. The block also reports queue misuse through sticky flags, one per beam for underflow and one for overflow.

Top module: `beam_seq`

## Requirements
- R1: A write is accepted only when `wr_en` is high and `wr_addr` equals `dev_addr`. Any other write changes no state, no output and no flag.
- R2: While `rst_n` is low, all outputs and flags are zero. After reset every beam selects the direct source, its direct state is zero, its queue is empty, and its table start, table end and table pointer are zero.
- R3: `beam_out` changes only in the cycle after a cycle with `upd` high. All beams and channels are loaded on that same edge, and host writes alone never alter `beam_out`.
- R4: The source select is written with `wr_kind`=5, with the mode in `wr_data[1:0]`: 0 selects direct, 1 selects stored, 2 selects queued, and 3 behaves as direct. The direct state is written with `wr_kind`=0. In direct mode a strobe copies the beam's direct state to its output.
- R5: The store is written with `wr_kind`=1 at `wr_index`. A table entry is written with `wr_kind`=2 at `wr_index`, with the store address in `wr_data[5:0]`. In stored mode a strobe outputs the state at the store address held in the table entry at the pointer. The pointer then moves to the table start if it equals the table end; otherwise it increments modulo 64.
- R6: Writing the table start (`wr_kind`=3) loads both the start and the pointer from `wr_index`. Writing the table end uses `wr_kind`=4.
- R7: `wr_kind`=6 appends `wr_data` to the beam's queue. In queued mode each strobe outputs the oldest remaining entry and removes it, so states come out strictly in load order, and up to 16 entries are held.
- R8: A strobe in queued mode with an empty queue leaves that beam's output unchanged and sets its bit of `fifo_under`. The bit stays set until it is cleared.
- R9: An append to a beam whose queue held 16 entries at the start of the cycle is dropped, even if a strobe pops in the same cycle. The drop sets that beam's bit of `fifo_over`, which stays set until it is cleared.
- R10: `wr_kind`=7 clears both flags of the addressed beam. When a clear and a flag-setting event fall in the same cycle, the clear wins.
- R11: Beams are independent. `wr_beam` selects the target beam. A write to one beam never changes another beam's storage, mode, pointer, flags or output.
- R12: Beam b occupies `beam_out[b*52 +: 52]`. Within a beam, channel c has its attenuation in bits `[c*13 +: 6]` and its delay in bits `[c*13+6 +: 7]`.
- R13: A strobe reads state as it stood before the edge. A write in the same cycle as a strobe (to the store, the table, the direct state or the mode) affects only later strobes. A start write in a strobe cycle overrides the pointer advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_addr | input | 4 | Strapped device address |
| wr_en | input | 1 | Host write valid |
| wr_addr | input | 4 | Device address carried by the write |
| wr_beam | input | 2 | Target beam |
| wr_kind | input | 3 | Write target code (0 direct, 1 store, 2 table, 3 start, 4 end, 5 mode, 6 append, 7 clear flags) |
| wr_index | input | 6 | Store or table index, or start/end value |
| wr_data | input | 52 | Beam state, table entry or mode value |
| upd | input | 1 | Update strobe for all beams |
| beam_out | output | 208 | Registered control words of all beams and channels |
| fifo_under | output | 4 | Sticky underflow flag per beam |
| fifo_over | output | 4 | Sticky overflow flag per beam |

## Verification
The bench builds the block with its default parameters: four beams of four channels, a 64-entry store and table, a 16-entry queue and a 4-bit device address. These sizes are small enough to fill every store and table entry at the start of the run and to drive a queue past its full point. The random phase then reaches table wrap with end below start, an append and a pop in the same cycle on a full queue, and writes that land in a strobe cycle. Device addresses that miss the pins are mixed into every phase.

// File: rtl/beam_seq.sv
module beam_seq #(
  parameter int NBEAM      = 4,
  parameter int NCH        = 4,
  parameter int AW         = 6,
  parameter int DW         = 7,
  parameter int RAM_DEPTH  = 64,
  parameter int FIFO_DEPTH = 16,
  parameter int ADRW       = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADRW-1:0]                    dev_addr,
  input  logic                               wr_en,
  input  logic [ADRW-1:0]                    wr_addr,
  input  logic [$clog2(NBEAM)-1:0]           wr_beam,
  input  logic [2:0]                         wr_kind,
  input  logic [$clog2(RAM_DEPTH)-1:0]       wr_index,
  input  logic [NCH*(AW+DW)-1:0]             wr_data,
  input  logic                               upd,
  output logic [NBEAM*NCH*(AW+DW)-1:0]       beam_out,
  output logic [NBEAM-1:0]                   fifo_under,
  output logic [NBEAM-1:0]                   fifo_over
);

  localparam int SW = NCH * (AW + DW);
  localparam int IW = $clog2(RAM_DEPTH);
  localparam int FW = $clog2(FIFO_DEPTH);
  localparam int BW = $clog2(NBEAM);
  localparam logic [FW:0] CNT_FULL = (FW+1)'(FIFO_DEPTH);

  localparam logic [2:0] K_DIR   = 3'd0;
  localparam logic [2:0] K_RAM   = 3'd1;
  localparam logic [2:0] K_SEQ   = 3'd2;
  localparam logic [2:0] K_START = 3'd3;
  localparam logic [2:0] K_END   = 3'd4;
  localparam logic [2:0] K_MODE  = 3'd5;
  localparam logic [2:0] K_PUSH  = 3'd6;
  localparam logic [2:0] K_CLR   = 3'd7;

  localparam logic [1:0] M_DIR  = 2'd0;
  localparam logic [1:0] M_RAM  = 2'd1;
  localparam logic [1:0] M_FIFO = 2'd2;

  logic [SW-1:0]  ram_m  [NBEAM][RAM_DEPTH];
  logic [IW-1:0]  seq_m  [NBEAM][RAM_DEPTH];
  logic [SW-1:0]  fifo_m [NBEAM][FIFO_DEPTH];

  logic [SW-1:0]  dir_q   [NBEAM];
  logic [SW-1:0]  out_q   [NBEAM];
  logic [1:0]     mode_q  [NBEAM];
  logic [IW-1:0]  ptr_q   [NBEAM];
  logic [IW-1:0]  first_q [NBEAM];
  logic [IW-1:0]  last_q  [NBEAM];
  logic [FW-1:0]  rd_q    [NBEAM];
  logic [FW-1:0]  wp_q    [NBEAM];
  logic [FW:0]    cnt_q   [NBEAM];

  logic [NBEAM-1:0] hit, push, pop, starve;
  logic sel;

  assign sel = wr_en && (wr_addr == dev_addr);

  always_comb begin
    for (int b = 0; b < NBEAM; b++) begin
      hit[b]    = sel && (wr_beam == BW'(b));
      push[b]   = hit[b] && (wr_kind == K_PUSH) && (cnt_q[b] != CNT_FULL);
      pop[b]    = upd && (mode_q[b] == M_FIFO) && (cnt_q[b] != '0);
      starve[b] = upd && (mode_q[b] == M_FIFO) && (cnt_q[b] == '0);
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBEAM; b++) begin
      if (hit[b] && wr_kind == K_RAM) ram_m[b][wr_index] <= wr_data;
      if (hit[b] && wr_kind == K_SEQ) seq_m[b][wr_index] <= wr_data[IW-1:0];
      if (push[b])                    fifo_m[b][wp_q[b]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBEAM; b++) begin
        out_q[b]   <= '0;
        dir_q[b]   <= '0;
        mode_q[b]  <= M_DIR;
        ptr_q[b]   <= '0;
        first_q[b] <= '0;
        last_q[b]  <= '0;
        rd_q[b]    <= '0;
        wp_q[b]    <= '0;
        cnt_q[b]   <= '0;
      end
      fifo_under <= '0;
      fifo_over  <= '0;
    end else begin
      for (int b = 0; b < NBEAM; b++) begin
        if (upd) begin
          case (mode_q[b])
            M_RAM: begin
              out_q[b] <= ram_m[b][seq_m[b][ptr_q[b]]];
              ptr_q[b] <= (ptr_q[b] == last_q[b]) ? first_q[b] : ptr_q[b] + 1'b1;
            end
            M_FIFO:  if (pop[b]) out_q[b] <= fifo_m[b][rd_q[b]];
            default: out_q[b] <= dir_q[b];
          endcase
        end
        if (starve[b]) fifo_under[b] <= 1'b1;
        if (pop[b])    rd_q[b] <= rd_q[b] + 1'b1;
        if (push[b])   wp_q[b] <= wp_q[b] + 1'b1;
        cnt_q[b] <= cnt_q[b] + (FW+1)'(push[b]) - (FW+1)'(pop[b]);

        if (hit[b]) begin
          case (wr_kind)
            K_DIR:   dir_q[b] <= wr_data;
            K_START: begin
              first_q[b] <= wr_index;
              ptr_q[b]   <= wr_index;
            end
            K_END:   last_q[b] <= wr_index;
            K_MODE:  mode_q[b] <= wr_data[1:0];
            K_PUSH:  if (!push[b]) fifo_over[b] <= 1'b1;
            K_CLR: begin
              fifo_under[b] <= 1'b0;
              fifo_over[b]  <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NBEAM; g++) begin : g_out
    assign beam_out[g*SW +: SW] = out_q[g];
  end

endmodule

// File: rtl/beam_seq_chk.sv
module beam_seq_chk #(
  parameter int NBEAM = 4,
  parameter int NCH   = 4,
  parameter int AW    = 6,
  parameter int DW    = 7,
  parameter int ADRW  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          upd,
  input logic                          wr_en,
  input logic [ADRW-1:0]               wr_addr,
  input logic [ADRW-1:0]               dev_addr,
  input logic [NBEAM*NCH*(AW+DW)-1:0]  beam_out,
  input logic [NBEAM-1:0]              fifo_under,
  input logic [NBEAM-1:0]              fifo_over
);

  logic sel;
  assign sel = wr_en && (wr_addr == dev_addr);

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(beam_out));

  // R8
  under_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ((fifo_under & $past(fifo_under)) == $past(fifo_under)));

  // R9
  over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ((fifo_over & $past(fifo_over)) == $past(fifo_over)));

  // R8
  under_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fifo_under & ~$past(fifo_under)) != '0) |-> $past(upd));

  // R9
  over_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fifo_over & ~$past(fifo_over)) != '0) |-> $past(sel));

endmodule

bind beam_seq beam_seq_chk #(
  .NBEAM(NBEAM), .NCH(NCH), .AW(AW), .DW(DW), .ADRW(ADRW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .wr_en(wr_en), .wr_addr(wr_addr),
  .dev_addr(dev_addr), .beam_out(beam_out), .fifo_under(fifo_under),
  .fifo_over(fifo_over)
);

// File: tb/beam_seq_tb.sv
`timescale 1ns/1ps
module beam_seq_tb;

  localparam int NB = 4;
  localparam int SW = 52;
  localparam logic [3:0] DEV = 4'hA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [1:0] wr_beam = '0;
  logic [2:0] wr_kind = '0;
  logic [5:0] wr_index = '0;
  logic [SW-1:0] wr_data = '0;
  logic upd = 1'b0;
  logic [NB*SW-1:0] beam_out;
  logic [NB-1:0] fifo_under, fifo_over;

  always #4 clk = ~clk;

  beam_seq u_dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(DEV), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_beam(wr_beam), .wr_kind(wr_kind), .wr_index(wr_index), .wr_data(wr_data),
    .upd(upd), .beam_out(beam_out), .fifo_under(fifo_under), .fifo_over(fifo_over)
  );

  int checks = 0;
  int fails = 0;
  int ncyc = 0;
  string cur_req = "R2";

  // behavioural reference
  logic [SW-1:0] m_ram [NB][64];
  int            m_seq [NB][64];
  logic [SW-1:0] m_q   [NB][$];
  logic [SW-1:0] m_dir [NB];
  logic [SW-1:0] m_out [NB];
  int m_mode [NB];
  int m_ptr [NB];
  int m_first [NB];
  int m_last [NB];
  bit m_under [NB];
  bit m_over [NB];
  bit full_pre [NB];

  always @(posedge clk) begin
    ncyc <= ncyc + 1;
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_q[b].delete();
        m_dir[b] = '0; m_out[b] = '0; m_mode[b] = 0;
        m_ptr[b] = 0; m_first[b] = 0; m_last[b] = 0;
        m_under[b] = 0; m_over[b] = 0;
      end
    end else begin
      for (int b = 0; b < NB; b++) full_pre[b] = (m_q[b].size() == 16);
      if (upd) begin
        for (int b = 0; b < NB; b++) begin
          if (m_mode[b] == 1) begin
            m_out[b] = m_ram[b][m_seq[b][m_ptr[b]]];
            m_ptr[b] = (m_ptr[b] == m_last[b]) ? m_first[b] : (m_ptr[b] + 1) % 64;
          end else if (m_mode[b] == 2) begin
            if (m_q[b].size() > 0) m_out[b] = m_q[b].pop_front();
            else m_under[b] = 1;
          end else begin
            m_out[b] = m_dir[b];
          end
        end
      end
      if (wr_en && wr_addr == DEV) begin
        case (wr_kind)
          3'd0: m_dir[wr_beam] = wr_data;
          3'd1: m_ram[wr_beam][wr_index] = wr_data;
          3'd2: m_seq[wr_beam][wr_index] = int'(wr_data[5:0]);
          3'd3: begin m_first[wr_beam] = int'(wr_index); m_ptr[wr_beam] = int'(wr_index); end
          3'd4: m_last[wr_beam] = int'(wr_index);
          3'd5: m_mode[wr_beam] = int'(wr_data[1:0]);
          3'd6: if (full_pre[wr_beam]) m_over[wr_beam] = 1;
                else m_q[wr_beam].push_back(wr_data);
          default: begin m_under[wr_beam] = 0; m_over[wr_beam] = 0; end
        endcase
      end
    end
  end

  function automatic logic [SW-1:0] getb(input int b);
    return beam_out[b*SW +: SW];
  endfunction

  function automatic logic [SW-1:0] pat(input int b, input int i);
    return SW'(b * 100003 + i * 7919 + 1) ^ (SW'(i) << 33);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (ncyc >= 2) begin
      bit ok;
      ok = 1;
      for (int b = 0; b < NB; b++) begin
        if (getb(b) !== m_out[b] || fifo_under[b] !== m_under[b] || fifo_over[b] !== m_over[b]) ok = 0;
      end
      checks++;
      if (!ok) begin
        fails++;
        for (int b = 0; b < NB; b++)
          $display("FAIL %s beam%0d actual=%h/%b/%b expected=%h/%b/%b", cur_req, b,
                   getb(b), fifo_under[b], fifo_over[b], m_out[b], m_under[b], m_over[b]);
      end
    end
  end

  task automatic cyc(input logic en, input logic [3:0] a, input int b, input logic [2:0] k,
                     input int idx, input logic [SW-1:0] d, input logic u);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_beam = 2'(b); wr_kind = k;
    wr_index = 6'(idx); wr_data = d; upd = u;
  endtask

  task automatic w(input int b, input logic [2:0] k, input int idx, input logic [SW-1:0] d);
    cyc(1'b1, DEV, b, k, idx, d, 1'b0);
  endtask

  task automatic strobe();
    cyc(1'b0, DEV, 0, 3'd0, 0, '0, 1'b1);
  endtask

  task automatic idle();
    cyc(1'b0, DEV, 0, 3'd0, 0, '0, 1'b0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    report();
  end

  initial begin
    int order [4];
    order = '{5, 2, 9, 2};
    repeat (3) @(negedge clk);
    // R2
    chk("R2", "beam_out in reset", 64'(beam_out == '0), 64'd1);
    chk("R2", "flags in reset", 64'({fifo_under, fifo_over}), 64'd0);
    rst_n = 1'b1;
    idle();

    cur_req = "R1";
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 64; i++) begin
        w(b, 3'd1, i, pat(b, i));
        w(b, 3'd2, i, SW'(i));
      end
    // R1: foreign address
    cyc(1'b1, DEV ^ 4'h3, 0, 3'd0, 0, pat(7, 7), 1'b0);
    cyc(1'b1, DEV ^ 4'h1, 0, 3'd5, 0, SW'(1), 1'b0);
    strobe(); idle();
    chk("R1", "beam0 after foreign writes", 64'(getb(0)), 64'd0);

    // R4 and R3, R12
    cur_req = "R4";
    for (int b = 0; b < NB; b++) w(b, 3'd0, 0, pat(20 + b, 3));
    idle();
    chk("R3", "no change before strobe", 64'(getb(1)), 64'd0);
    strobe(); idle();
    for (int b = 0; b < NB; b++) chk("R4", "direct state", 64'(getb(b)), 64'(pat(20 + b, 3)));
    w(3, 3'd0, 0, SW'(7'h55) << (2*13 + 6));
    w(3, 3'd5, 0, SW'(3));
    strobe(); idle();
    chk("R12", "channel 2 delay field", 64'(beam_out[3*SW + 2*13 + 6 +: 7]), 64'h55);
    chk("R4", "mode 3 acts as direct", 64'(getb(3)), 64'(SW'(7'h55) << 32));

    // R5 / R6 stored playback with wrap
    cur_req = "R5";
    for (int j = 0; j < 4; j++) w(1, 3'd2, j, SW'(order[j]));
    w(1, 3'd3, 0, '0);
    w(1, 3'd4, 3, '0);
    w(1, 3'd5, 0, SW'(1));
    for (int j = 0; j < 6; j++) begin
      strobe(); idle();
      chk("R5", "stored order", 64'(getb(1)), 64'(pat(1, order[j % 4])));
    end
    // R11
    chk("R11", "beam0 untouched", 64'(getb(0)), 64'(pat(20, 3)));
    // R6: start rewrites pointer
    w(1, 3'd3, 2, '0);
    w(1, 3'd4, 2, '0);
    strobe(); idle();
    chk("R6", "pointer at new start", 64'(getb(1)), 64'(pat(1, 9)));
    w(1, 3'd5, 0, SW'(0));

    // R7 / R9 queue fill and overflow
    cur_req = "R7";
    for (int k = 0; k < 17; k++) w(2, 3'd6, 0, pat(9, k));
    idle();
    chk("R9", "overflow flag", 64'(fifo_over), 64'b0100);
    w(2, 3'd5, 0, SW'(2));
    for (int k = 0; k < 16; k++) begin
      strobe(); idle();
      chk("R7", "load order", 64'(getb(2)), 64'(pat(9, k)));
    end
    // R8
    strobe(); idle();
    chk("R8", "held on empty", 64'(getb(2)), 64'(pat(9, 15)));
    chk("R8", "underflow flag", 64'(fifo_under), 64'b0100);
    idle();
    chk("R8", "underflow sticky", 64'(fifo_under), 64'b0100);
    // R10
    w(2, 3'd7, 0, '0);
    idle();
    chk("R10", "flags cleared", 64'({fifo_under, fifo_over}), 64'd0);
    // R13: write during strobe affects only later strobes
    cur_req = "R13";
    w(0, 3'd0, 0, pat(30, 1));
    cyc(1'b1, DEV, 0, 3'd0, 0, pat(31, 1), 1'b1);
    idle();
    chk("R13", "strobe uses old direct", 64'(getb(0)), 64'(pat(30, 1)));

    // random mixed traffic
    cur_req = "R11";
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] r;
      int k;
      r = {$urandom, $urandom};
      k = int'($urandom % 10);
      if (k > 7) k = 6;
      cyc(($urandom % 2) == 0, (($urandom % 4) == 0) ? (DEV ^ 4'h8) : DEV,
          int'($urandom % 4), 3'(k), int'($urandom % 64), r[51:0], ($urandom % 3) == 0);
    end
    idle(); idle();
    report();
  end

endmodule